// File: doc/BRIEF.md
# Serial Configuration Port with Frame-Length Check

This block is the slave side of a four-wire serial setup port for a motor gate pre-driver. A host drives an active-low select line, a serial clock of a few megahertz and a data line. The block runs entirely on a faster system clock. It passes the three incoming lines through two-stage synchronisers and finds their edges in the system clock domain.

While select is low, the block takes one data bit on every falling serial-clock edge, most significant bit first, into a command shift register. At the same time it shifts a status byte out on the data-out line. When select returns high, the frame is judged by its bit count. A count of exactly `CMD_W` hands the word to the downstream register decoder with a single-cycle strobe. Any other count, including zero, discards the word and sets a sticky error flag. The host sees that flag in the next status byte, and the flag clears once it has been reported.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, `cmd_valid_o` is 0, `cmd_o` is 0, `frame_err_o` is 0 and `so_oe_o` is 0.
- R2: `so_oe_o` is 0 (data-out released, high-impedance) whenever select is high, and 1 while select is low.
- R3: `si_i` is sampled on each falling edge of `sclk_i` while select is low, and the first bit is taken as the MSB. A frame of exactly 8 falling edges places the received byte on `cmd_o` after select rises.
- R4: `cmd_valid_o` is high for exactly one system-clock cycle per accepted frame, only after select has risen, and never while select is low.
- R5: A frame with a falling-edge count other than 8 (fewer or more) sets `frame_err_o`, produces no `cmd_valid_o` pulse and leaves `cmd_o` unchanged.
- R6: A frame in which select falls and rises with no serial-clock edge sets `frame_err_o`.
- R7: The status byte is {bit 7 = error flag, bits 6:0 = bits 6:0 of the last accepted command}. It is captured when select falls and sent MSB first. Bit 7 is on `so_o` once select is low, and each rising `sclk_i` edge moves the next lower bit onto `so_o`.
- R8: The error flag is sticky while idle. It clears at the end of a well-formed frame whose status byte carried it as 1. A malformed frame sets it again.
- R9: The asynchronous active-low reset `rst_n` clears the error flag, the bit counter and the shift registers, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, must oversample `sclk_i` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host (idle low) |
| cs_n_i | input | 1 | Active-low select, frames each command |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out (status byte) |
| so_oe_o | output | 1 | Drive enable for data-out pad; 0 = high-impedance |
| cmd_o | output | CMD_W | Last accepted command word |
| cmd_valid_o | output | 1 | One-cycle strobe for a new command |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
The bench aims at frames one bit short, frames one bit long and frames with no clock at all. A design that only checked for overflow, or that ignored empty frames, would strobe a bad word or leave the error flag low. It reads the status byte back bit by bit, before and after an error. An off-by-one shift would show a wrong or rotated byte, and a flag that never clears, or clears before it is shown, would give the wrong bit 7. A reset in the middle of a frame must leave no error and no strobe behind.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_END   = 2'd2
    } frame_ev_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
    import spi_cfg_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             cs_n_s,
    input  logic             si_s,
    output logic             so_o,
    output logic             so_oe_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             cmd_valid_o,
    output logic             frame_err_o
);
    localparam int CNT_W = $clog2(CMD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CMD_W + 1);

    typedef struct packed {
        logic [CMD_W-1:0] rx;
        logic [CMD_W-1:0] tx;
        logic [CMD_W-1:0] cmd;
        logic [CNT_W-1:0] cnt;
        logic             sclk_p;
        logic             cs_p;
        logic             err;
        logic             err_shown;
        logic             vld;
    } state_t;

    state_t    q, d;
    frame_ev_e ev;
    logic      sclk_fall, sclk_rise;

    always_comb begin
        ev = EV_NONE;
        if (q.cs_p && !cs_n_s)      ev = EV_START;
        else if (!q.cs_p && cs_n_s) ev = EV_END;
        sclk_fall = q.sclk_p && !sclk_s;
        sclk_rise = !q.sclk_p && sclk_s;
    end

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        d.cs_p   = cs_n_s;
        d.sclk_p = sclk_s;
        case (ev)
            EV_START: begin
                d.cnt       = '0;
                d.tx        = {q.err, q.cmd[CMD_W-2:0]};
                d.err_shown = q.err;
            end
            EV_END: begin
                if (q.cnt == CNT_FULL) begin
                    d.cmd = q.rx;
                    d.vld = 1'b1;
                    d.err = q.err & ~q.err_shown;
                end else begin
                    d.err = 1'b1;
                end
                d.err_shown = 1'b0;
            end
            default: begin
                if (!cs_n_s) begin
                    if (sclk_fall) begin
                        d.rx = {q.rx[CMD_W-2:0], si_s};
                        if (q.cnt != CNT_SAT) d.cnt = q.cnt + 1'b1;
                    end
                    if (sclk_rise) begin
                        d.tx = {q.tx[CMD_W-2:0], 1'b0};
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_p   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign so_oe_o     = ~cs_n_s;
    assign so_o        = so_oe_o & q.tx[CMD_W-1];
    assign cmd_o       = q.cmd;
    assign cmd_valid_o = q.vld;
    assign frame_err_o = q.err;

    // R4: strobe lasts one cycle
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    // R4: strobe never while select is low
    p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cs_n_s);
    // R5: error only appears at the end of a frame
    p_err_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> $past(cs_n_s) && !$past(q.cs_p));
    // R5: a rejected frame never strobes
    p_no_valid_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> !cmd_valid_o);
    // R3: command word changes only with its strobe
    p_cmd_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> $stable(cmd_o));
    // R2: data-out is quiet whenever it is released
    p_so_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe_o |-> !so_o);
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port #(
    parameter int CMD_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             cs_n_i,
    input  logic             si_i,
    output logic             so_o,
    output logic             so_oe_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             cmd_valid_o,
    output logic             frame_err_o
);
    logic sclk_s, cs_n_s, si_s;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cs_n_i, sclk_i, si_i}),
        .sync_o ({cs_n_s, sclk_s, si_s})
    );

    spi_frame #(
        .CMD_W(CMD_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .cs_n_s     (cs_n_s),
        .si_s       (si_s),
        .so_o       (so_o),
        .so_oe_o    (so_oe_o),
        .cmd_o      (cmd_o),
        .cmd_valid_o(cmd_valid_o),
        .frame_err_o(frame_err_o)
    );
endmodule

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
    localparam int CLK_P = 10;
    localparam int GAP   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       so, so_oe, vld, err;
    logic [7:0] cmd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] seen_status;
    int         pulses;

    always #(CLK_P/2) clk = ~clk;

    spi_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .si_i(si),
        .so_o(so), .so_oe_o(so_oe), .cmd_o(cmd), .cmd_valid_o(vld),
        .frame_err_o(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] word, input int nbits);
        seen_status = '0;
        pulses = 0;
        cs_n = 1'b0;
        wait_clk(GAP);
        check("R2 oe in frame", so_oe, 1'b1);
        for (int i = 0; i < nbits; i++) begin
            si = (i < 8) ? word[7-i] : 1'b0;
            if (i < 8) seen_status[7-i] = so;
            sclk = 1'b1;
            wait_clk(GAP);
            sclk = 1'b0;
            wait_clk(GAP);
        end
        cs_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (vld) pulses++;
        end
    endtask

    task automatic t_reset;
        wait_clk(3);
        check("R1 valid", vld, 1'b0);
        check("R1 cmd", cmd, 8'h00);
        check("R1 err", err, 1'b0);
        check("R1 oe", so_oe, 1'b0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R2 oe idle", so_oe, 1'b0);
    endtask

    task automatic t_good(input logic [7:0] word, input logic [7:0] exp_status, input logic exp_err);
        run_frame(word, 8);
        check("R3 cmd", cmd, word);
        check("R4 one pulse", pulses, 1);
        check("R7 status", seen_status, exp_status);
        check("R8 err after good", err, exp_err);
        check("R2 oe after", so_oe, 1'b0);
    endtask

    task automatic t_bad(input int nbits, input logic [7:0] keep);
        run_frame(8'hFF, nbits);
        check("R5 err set", err, 1'b1);
        check("R5 no pulse", pulses, 0);
        check("R5 cmd kept", cmd, keep);
        wait_clk(20);
        check("R8 sticky", err, 1'b1);
    endtask

    task automatic t_zero(input logic [7:0] keep);
        run_frame(8'h00, 0);
        check("R6 err on empty", err, 1'b1);
        check("R6 no pulse", pulses, 0);
        check("R6 cmd kept", cmd, keep);
    endtask

    task automatic t_reset_mid;
        cs_n = 1'b0;
        wait_clk(GAP);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; wait_clk(GAP);
            sclk = 1'b0; wait_clk(GAP);
        end
        rst_n = 1'b0;
        wait_clk(2);
        check("R9 err cleared", err, 1'b0);
        check("R9 cmd cleared", cmd, 8'h00);
        check("R9 oe released", so_oe, 1'b0);
        cs_n = 1'b1;
        rst_n = 1'b1;
        wait_clk(10);
        check("R9 no err after", err, 1'b0);
        check("R9 no strobe", vld, 1'b0);
    endtask

    initial begin
        t_reset();
        t_good(8'hA5, 8'h00, 1'b0);
        t_good(8'h3C, 8'h25, 1'b0);
        t_bad(5, 8'h3C);
        t_good(8'h3C, 8'hBC, 1'b0);
        t_bad(9, 8'h3C);
        t_good(8'h41, 8'hBC, 1'b0);
        t_zero(8'h41);
        t_good(8'h12, 8'hC1, 1'b0);
        t_good(8'h7E, 8'h12, 1'b0);
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule